// File: doc/BRIEF.md
# Self-Resolving Bitwise Bus Contention

This block settles bus ownership among a set of potential masters with no central decision point. Each node carries a fixed, distinct contention number derived from its position. When the bus is free and any node is requesting, a contention phase begins. Every requester present at that moment places its number on a shared wired-OR line one bit at a time, most significant bit first. A node that sees the line at 1 while its own bit is 0 has lost to a larger number. It withdraws and stays silent for the rest of the phase. After the least significant bit, only the node with the largest number is still competing. That node takes the bus.

The request and grant pins are level control signals, not a data stream, so no valid/ready handshake applies. A node keeps `req` high for as long as it wants to compete or to keep the bus. The owner frees the bus by lowering its request. The next phase can then start on the following cycle. Requests that rise while a phase is running are not seen until the next phase.

Top module: `dab_bus_arb`

## Requirements
- R1: After reset, `grant` is all zeros and `bus_busy`, `arb_phase` and `arb_line` are 0.
- R2: A phase starts on a clock edge where the bus is idle (`arb_phase` = 0, `bus_busy` = 0) and `req` is nonzero. `arb_phase` is then high for exactly ID_W cycles. `bus_busy` rises on the edge that ends the phase, and `arb_phase` and `bus_busy` are never high together.
- R3: The node granted is the one with the largest contention number among the nodes whose `req` bit was high on the starting edge.
- R4: While `bus_busy` is 1, exactly one bit of `grant` is set. While `bus_busy` is 0, `grant` is zero.
- R5: A request that rises during a phase does not take part in that phase, even when its number is the largest.
- R6: `grant` stays unchanged while the owner's `req` bit stays high, whatever the other request bits do. On the edge after the owner's `req` bit is seen low, `grant` and `bus_busy` return to 0.
- R7: `arb_line` is 0 outside a phase. During the k-th cycle of a phase (k = 1..ID_W), it shows bit ID_W-k of the winning number.
- R8: Node i has contention number (i*ID_STRIDE + ID_OFFSET) mod 2^ID_W. With the defaults (8 nodes, stride 5, offset 3) the numbers for nodes 0..7 are 3, 8, 13, 2, 7, 12, 1, 6.
- R9: A node that was requesting on the starting edge stays in the contest if it lowers `req` during the phase. If it wins, it receives `grant` for one cycle and then releases the bus under R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NODES | Per-node bus request level |
| grant | output | NODES | One-hot bus ownership |
| bus_busy | output | 1 | Bus held by a granted node |
| arb_phase | output | 1 | Contention phase in progress |
| arb_line | output | 1 | Wired-OR contention line for the current bit |

## Verification
A node that withdraws wrongly, or fails to withdraw, shows up on `arb_line` in the very cycle its bit is resolved. It shows up again ID_W cycles after the start as a grant to a node other than the largest snapshot requester, or as more than one grant bit. A sequencer fault shows up as a phase that is too short or too long, seen as a late or early `bus_busy`. A snapshot fault shows up as a grant going to a late requester. The bench sweeps every nonzero request mask and checks the line bit by bit, so each of these faults is reported within one phase.

// File: rtl/dab_pkg.sv
package dab_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ARB  = 2'd1,
    PH_OWN  = 2'd2
  } phase_e;

  // Contention number for node idx (unique while stride is odd and
  // the node count does not exceed 2**width).
  function automatic int unsigned node_num(int unsigned idx, int unsigned stride,
                                           int unsigned offset, int unsigned width);
    return (idx * stride + offset) % (32'd1 << width);
  endfunction

endpackage

// File: rtl/dab_seq.sv
module dab_seq #(
  parameter int unsigned ID_W  = 4,
  localparam int unsigned BIT_W = (ID_W > 1) ? $clog2(ID_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_req,
  input  logic             owner_req,
  output dab_pkg::phase_e  phase,
  output logic [BIT_W-1:0] bit_idx,
  output logic             start,
  output logic             step,
  output logic             clear
);
  import dab_pkg::*;

  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(ID_W - 1);

  phase_e phase_q, phase_d;
  logic [BIT_W-1:0] idx_q, idx_d;

  assign start = (phase_q == PH_IDLE) && any_req;
  assign step  = (phase_q == PH_ARB);
  assign clear = (phase_q == PH_OWN) && !owner_req;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (any_req) begin
          phase_d = PH_ARB;
          idx_d   = TOP_BIT;
        end
      end
      PH_ARB: begin
        if (idx_q == '0) phase_d = PH_OWN;
        else             idx_d   = idx_q - 1'b1;
      end
      PH_OWN: begin
        if (!owner_req) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  assign phase   = phase_q;
  assign bit_idx = idx_q;

endmodule

// File: rtl/dab_node.sv
module dab_node #(
  parameter int unsigned ID_W    = 4,
  parameter int unsigned NODE_ID = 0,
  localparam int unsigned BIT_W  = (ID_W > 1) ? $clog2(ID_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic             clear,
  input  logic             own_phase,
  input  logic             req_i,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             line_i,
  output logic             drive_o,
  output logic             grant_o
);
  localparam logic [ID_W-1:0] MY_NUM = ID_W'(NODE_ID);

  logic competing_q;
  logic my_bit;

  assign my_bit = MY_NUM[bit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)                                 competing_q <= 1'b0;
    else if (start)                             competing_q <= req_i;
    else if (step && competing_q && !my_bit && line_i) competing_q <= 1'b0;
    else if (clear)                             competing_q <= 1'b0;
  end

  assign drive_o = step && competing_q && my_bit;
  assign grant_o = own_phase && competing_q;

endmodule

// File: rtl/dab_wor.sv
module dab_wor #(
  parameter int unsigned NODES = 8
) (
  input  logic [NODES-1:0] drv,
  output logic             line
);
  logic [NODES:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < NODES; i++) begin : g_or
    assign chain[i+1] = chain[i] | drv[i];
  end
  assign line = chain[NODES];
endmodule

// File: rtl/dab_bus_arb.sv
module dab_bus_arb #(
  parameter int unsigned NODES     = 8,
  parameter int unsigned ID_W      = 4,
  parameter int unsigned ID_STRIDE = 5,
  parameter int unsigned ID_OFFSET = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NODES-1:0] req,
  output logic [NODES-1:0] grant,
  output logic             bus_busy,
  output logic             arb_phase,
  output logic             arb_line
);
  import dab_pkg::*;

  localparam int unsigned BIT_W = (ID_W > 1) ? $clog2(ID_W) : 1;

  phase_e           phase;
  logic [BIT_W-1:0] bit_idx;
  logic             start, step, clear;
  logic [NODES-1:0] drv;
  logic             line;
  logic             owner_req;

  assign owner_req = |(req & grant);

  dab_seq #(.ID_W(ID_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .any_req(|req), .owner_req(owner_req),
    .phase(phase), .bit_idx(bit_idx), .start(start), .step(step), .clear(clear)
  );

  for (genvar i = 0; i < NODES; i++) begin : g_node
    dab_node #(
      .ID_W(ID_W),
      .NODE_ID(node_num(i, ID_STRIDE, ID_OFFSET, ID_W))
    ) node_i (
      .clk(clk), .rst_n(rst_n), .start(start), .step(step), .clear(clear),
      .own_phase(phase == PH_OWN), .req_i(req[i]), .bit_idx(bit_idx),
      .line_i(line), .drive_o(drv[i]), .grant_o(grant[i])
    );
  end

  dab_wor #(.NODES(NODES)) wor_i (.drv(drv), .line(line));

  assign arb_line  = line;
  assign arb_phase = (phase == PH_ARB);
  assign bus_busy  = (phase == PH_OWN);

endmodule

// File: rtl/dab_chk.sv
module dab_chk #(
  parameter int unsigned NODES = 8,
  parameter int unsigned ID_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NODES-1:0] req,
  input logic [NODES-1:0] grant,
  input logic             bus_busy,
  input logic             arb_phase,
  input logic             arb_line
);
  int unsigned arb_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         arb_cnt <= 0;
    else if (arb_phase) arb_cnt <= arb_cnt + 1;
    else                arb_cnt <= 0;
  end

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(arb_phase && bus_busy));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_phase && !bus_busy && |req) |=> arb_phase);

  p_phase_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_phase && arb_cnt == ID_W - 1) |=> (!arb_phase && bus_busy));

  p_busy_from_arb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> $past(arb_phase));

  p_one_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> ($countones(grant) == 1));

  p_no_grant_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |-> (grant == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && |(grant & req)) |=> ($stable(grant) && bus_busy));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !(|(grant & req))) |=> !bus_busy);

  p_line_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_phase |-> !arb_line);

endmodule

bind dab_bus_arb dab_chk #(.NODES(NODES), .ID_W(ID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .grant(grant),
  .bus_busy(bus_busy), .arb_phase(arb_phase), .arb_line(arb_line)
);

// File: tb/dab_bus_arb_tb.sv
module dab_bus_arb_tb_top;
  localparam int N = 8;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] grant;
  logic         bus_busy, arb_phase, arb_line;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dab_bus_arb #(.NODES(N), .ID_W(W), .ID_STRIDE(5), .ID_OFFSET(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .grant(grant),
    .bus_busy(bus_busy), .arb_phase(arb_phase), .arb_line(arb_line)
  );

  // R8: number of node i
  function automatic int num_of(int i);
    return (i * 5 + 3) % 16;
  endfunction

  function automatic int win_of(logic [N-1:0] m);
    int best = -1;
    int bi = 0;
    for (int i = 0; i < N; i++)
      if (m[i] && num_of(i) > best) begin
        best = num_of(i);
        bi = i;
      end
    return bi;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Run the ID_W contention cycles, checking the line against the winner (R7, R3).
  task automatic run_bits(input int w);
    for (int b = W - 1; b >= 0; b--) begin
      tick();
      chk(arb_phase == 1'b1, "R2 phase active", arb_phase, 1);
      chk(arb_line == num_of(w)[b], "R7 line bit", arb_line, num_of(w)[b]);
    end
    tick();
    chk(grant == N'(1 << w), "R3 winner", grant, 1 << w);
    chk(bus_busy == 1'b1 && arb_phase == 1'b0, "R4 busy after phase", bus_busy, 1);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick();
    chk(grant == '0 && !bus_busy && !arb_phase && !arb_line, "R1 reset state",
        {grant, bus_busy, arb_phase, arb_line}, 0);
    rst_n = 1'b1;
    tick();
    chk(!arb_phase && !bus_busy, "R2 stays idle without request", arb_phase, 0);

    // Exhaustive sweep over every nonzero request mask (R3, R4, R6, R7, R8).
    for (int m = 1; m < (1 << N); m++) begin
      req = N'(m);
      run_bits(win_of(N'(m)));
      tick();
      chk(grant == N'(1 << win_of(N'(m))), "R6 hold while requesting", grant, 1 << win_of(N'(m)));
      req = '0;
      tick();
      chk(grant == '0 && !bus_busy, "R6 release", grant, 0);
      tick();
      chk(!arb_phase && !bus_busy, "R2 idle after release", arb_phase, 0);
    end

    // R5: late request with the largest number waits.
    req = 8'b0000_0011;
    tick();
    req[2] = 1'b1;
    for (int b = W - 2; b >= 0; b--) tick();
    tick();
    chk(grant == 8'b0000_0010, "R5 late request ignored", grant, 8'h02);
    // R6: other requests toggling do not disturb the owner.
    req[0] = 1'b0;
    tick();
    req[0] = 1'b1;
    tick();
    chk(grant == 8'b0000_0010 && bus_busy, "R6 stable under others", grant, 8'h02);
    req[1] = 1'b0;
    tick();
    chk(!bus_busy && grant == '0, "R6 owner release", grant, 0);
    run_bits(2);
    req = '0;
    tick();
    tick();

    // R9: winner lowers its request mid-phase.
    req = 8'b0000_0101;
    tick();
    req[2] = 1'b0;
    for (int b = W - 2; b >= 0; b--) tick();
    tick();
    chk(grant == 8'b0000_0100, "R9 dropped requester still wins", grant, 8'h04);
    tick();
    chk(grant == '0 && !bus_busy, "R9 immediate release", grant, 0);
    tick();
    chk(arb_phase == 1'b1, "R9 next phase starts", arb_phase, 1);
    req = '0;
    for (int b = 0; b < W + 2; b++) tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule